// File: doc/BRIEF.md
# External Reset Pin Controller

This block controls a bidirectional, active-low reset line shared with devices outside the chip. It runs on the slow system clock. It brings the pin level in through a synchronizer and reports it in a status word. A falling edge caused by an outside device latches an event flag. That edge then either starts an internal user reset or raises an interrupt, depending on a mode bit. A one-cycle software request pulls the line low for a programmable, exponentially scaled number of cycles and holds the processor in reset until the line has recovered.

The block records the cause of the last processor reset and updates it only when the processor reset is released. The synchronous active-low `rst_n` input stands for the core-supply reset (power-on, brownout, regulator loss). It clears every register, including the mode word. It also makes the line low-drive last two cycles beyond its release. A small strobe bus gives access to a mode word at address 0 and a status word at address 1.

Top module: `ext_rst_pin_ctrl`

## Requirements
- R1: A software request accepted while the line is idle drives `pin_drive_lo` high for exactly min(2^(N+1), 2^CNT_W - 1) cycles, starting the cycle after the request edge, where N is mode bits [LEN_W-1:0].
- R2: With N = 0 the line is driven for exactly two cycles.
- R3: Status bit 1 reports the pin level after a two-flop synchronizer: it follows a change of `pin_in` two clock edges later.
- R4: Status bit 0 is set on the third edge after an outside device pulls the line low while the block is neither driving it nor in reset. It stays set until a bus read of address 1 with `bus_rd` high, which clears it on that edge.
- R5: With mode bit LEN_W (bit 4 by default) at 1, an outside low on the line raises `irq` together with status bit 0, and `proc_rst_n` stays high.
- R6: With that mode bit at 0, an outside low on the line drops `proc_rst_n` on the third edge. `proc_rst_n` rises on the third edge after the line returns high, and the reset type becomes 4.
- R7: The core-supply reset clears the mode word. It drives the line low while `rst_n` is low and for exactly two edges after `rst_n` rises. After release the reset type reads 0.
- R8: The reset type (status bits [10:8]: 0 general, 2 software, 4 user) changes only on the edge where `proc_rst_n` rises. A software reset reports 2.
- R9: A software request arriving while a line pulse runs is ignored and does not lengthen it.
- R10: The mode word keeps its value through software and user resets.
- R11: Bus writes to address 0 load the mode word, and `bus_rdata` shows the addressed word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Core-supply (general) reset, synchronous, active low |
| pin_in | input | 1 | Observed level of the external reset line |
| pin_drive_lo | output | 1 | High while the block pulls the line low |
| sw_rst_req | input | 1 | One-cycle software request for a reset with line pulse |
| proc_rst_n | output | 1 | Processor reset, active low |
| irq | output | 1 | Interrupt for an outside line assertion in interrupt mode |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the event flag on a status read) |
| bus_addr | input | 1 | 0 = mode word, 1 = status word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word |

## Verification
The bench builds the block with an 8-bit pulse counter, keeping LEN_W at 4 and DATA_W at 32. The narrow counter lets a sweep over all sixteen length codes run in a few thousand cycles. It also brings the saturation at 255 within reach from code 7 upward, alongside the unsaturated codes 0 to 6. The bench models the shared line as a wired-AND of an outside driver and the block's own drive. This exercises the self-masking of the block's own pulses and the exact synchronizer latencies.

// File: rtl/ext_rst_pkg.sv
// Shared encodings for the external reset pin controller.
// Assumes a status word of at least 11 bits.
package ext_rst_pkg;

    typedef enum logic [2:0] {
        RT_GENERAL = 3'd0,
        RT_SOFT    = 3'd2,
        RT_USER    = 3'd4
    } rst_kind_t;

    localparam int ST_FLAG_BIT = 0;
    localparam int ST_LVL_BIT  = 1;
    localparam int ST_TYPE_LSB = 8;

    localparam logic ADDR_MODE   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

endpackage

// File: rtl/erp_pin_sync.sv
// Brings the asynchronous pin level into the clock domain through a chain of
// STAGES flops and flags a high-to-low transition of the synchronized level.
// Assumes the line is held low during reset, so the chain resets to 0.
module erp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_in};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/erp_pulse_gen.sv
// Down counter that holds the line low for 2^(len+1) cycles, saturated to the
// counter's maximum. Requests while counting are dropped. Out of reset it
// runs the length for code 0, so the line stays low just past reset release.
module erp_pulse_gen #(
    parameter int LEN_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LEN_W-1:0] len,
    output logic             active,
    output logic             drive_lo
);
    function automatic logic [CNT_W-1:0] span(input logic [LEN_W-1:0] n);
        if (int'(n) + 1 >= CNT_W) return '1;
        return {{(CNT_W-1){1'b0}}, 1'b1} << (int'(n) + 1);
    endfunction

    localparam logic [CNT_W-1:0] RESET_SPAN = span('0);

    logic [CNT_W-1:0] cnt;

    // Load on an idle request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= RESET_SPAN;
        else if (req && !active)  cnt <= span(len);
        else if (active)          cnt <= cnt - 1'b1;
    end

    assign active   = |cnt;
    assign drive_lo = active;

    assert_pulse_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !active) |=> drive_lo);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && active) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/erp_regs.sv
// Mode word (length code and interrupt-mode bit) and the event flag, plus the
// combinational read mux. The flag is set by the event input and cleared by a
// strobed status read; a set in the same cycle wins.
module erp_regs
    import ext_rst_pkg::*;
#(
    parameter int LEN_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_set,
    input  logic              level,
    input  rst_kind_t         rst_type,
    output logic [DATA_W-1:0] rdata,
    output logic [LEN_W-1:0]  len,
    output logic              irq_en,
    output logic              flag
);
    localparam int IRQ_BIT = LEN_W;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:IRQ_BIT+1];

    // Mode word: cleared only by the core-supply reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len    <= '0;
            irq_en <= 1'b0;
        end else if (wr && addr == ADDR_MODE) begin
            len    <= wdata[LEN_W-1:0];
            irq_en <= wdata[IRQ_BIT];
        end
    end

    // Event flag: set on an outside assertion, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (evt_set)                     flag <= 1'b1;
        else if (rd && addr == ADDR_STATUS)   flag <= 1'b0;
    end

    // Read mux for the addressed word.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_MODE) begin
            rdata[LEN_W-1:0] = len;
            rdata[IRQ_BIT]   = irq_en;
        end else begin
            rdata[ST_FLAG_BIT]                = flag;
            rdata[ST_LVL_BIT]                 = level;
            rdata[ST_TYPE_LSB+2:ST_TYPE_LSB]  = rst_type;
        end
    end

    assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set |=> flag);

    assert_flag_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_STATUS && !evt_set) |=> !flag);
endmodule

// File: rtl/ext_rst_pin_ctrl.sv
// External reset pin controller: synchronizes the line, turns outside
// assertions into a user reset or an interrupt, pulses the line on software
// request, sequences the processor reset and records its cause.
// Assumes the line is a wired-AND of this block's drive and outside drivers.
module ext_rst_pin_ctrl
    import ext_rst_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    output logic              pin_drive_lo,
    input  logic              sw_rst_req,
    output logic              proc_rst_n,
    output logic              irq,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic             level, fall, active, evt, start_ok;
    logic             busy, irq_en, flag;
    logic [LEN_W-1:0] len;
    rst_kind_t        cause, rst_type;

    erp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level(level), .fall(fall)
    );

    erp_pulse_gen #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .req(sw_rst_req), .len(len),
        .active(active), .drive_lo(pin_drive_lo)
    );

    erp_regs #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .evt_set(evt), .level(level), .rst_type(rst_type),
        .rdata(bus_rdata), .len(len), .irq_en(irq_en), .flag(flag)
    );

    // Outside assertions only count while the block neither drives nor resets.
    assign evt      = fall & ~busy & ~active;
    assign start_ok = sw_rst_req & ~active;

    // Processor reset sequencing and cause recording at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b1;
            cause    <= RT_GENERAL;
            rst_type <= RT_GENERAL;
        end else if (start_ok) begin
            busy  <= 1'b1;
            cause <= RT_SOFT;
        end else if (evt && !irq_en) begin
            busy  <= 1'b1;
            cause <= RT_USER;
        end else if (busy && level && !active) begin
            busy     <= 1'b0;
            rst_type <= cause;
        end
    end

    assign proc_rst_n = ~busy;
    assign irq        = flag & irq_en;

    assert_type_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(rst_type)));

    assert_irq_no_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq_en && !sw_rst_req) |=> proc_rst_n);
endmodule

// File: tb/ext_rst_pin_ctrl_test.sv
`timescale 1ns/1ps
module ext_rst_pin_ctrl_test;
    localparam int LEN_W = 4, CNT_W = 8, DATA_W = 32;

    logic clk = 1'b0, rst_n = 1'b0, ext_lvl = 1'b1, sw_req = 1'b0;
    logic wr = 1'b0, rd = 1'b0, addr = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic pin_drive, proc_rst_n, irq;
    logic pin_line;
    int tests = 0, fails = 0;

    assign pin_line = ext_lvl & ~pin_drive;

    always #2.5 clk = ~clk;

    ext_rst_pin_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_line), .pin_drive_lo(pin_drive),
        .sw_rst_req(sw_req), .proc_rst_n(proc_rst_n), .irq(irq),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata)
    );

    task automatic check(string req, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic a, output logic [DATA_W-1:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic write_mode(logic [DATA_W-1:0] v);
        @(negedge clk); wr = 1'b1; addr = 1'b0; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic read_status(output logic [DATA_W-1:0] v);
        @(negedge clk); rd = 1'b1; addr = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_release();
        for (int g = 0; g < 1000 && !proc_rst_n; g++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        int n, exp_len;

        // General reset at start (R7)
        step(3);
        check("R7", "line driven during reset", pin_drive, 1);
        peek(1'b0, v);
        check("R7", "mode cleared", v[4:0], 0);
        rst_n = 1'b1;
        step(1);
        check("R7", "drive one edge after release", pin_drive, 1);
        step(1);
        check("R7", "drive two edges after release", pin_drive, 0);
        check("R7", "processor still in reset", proc_rst_n, 0);
        wait_release();
        check("R7", "processor released", proc_rst_n, 1);
        peek(1'b1, v);
        check("R7", "type general", v[10:8], 0);
        check("R3", "level high after release", v[1], 1);

        // Length sweep (R1, R2, R8, R10)
        for (int code = 0; code < 16; code++) begin
            write_mode(code);
            @(negedge clk); sw_req = 1'b1;
            @(negedge clk); sw_req = 1'b0;
            n = 0;
            while (pin_drive && n < 70000) begin n++; @(negedge clk); end
            exp_len = (code + 1 >= CNT_W) ? (1 << CNT_W) - 1 : (1 << (code + 1));
            check(code == 0 ? "R2" : "R1", $sformatf("pulse length code %0d", code), n, exp_len);
            check("R8", "held in reset after pulse", proc_rst_n, 0);
            wait_release();
            peek(1'b1, v);
            check("R8", "type software", v[10:8], 2);
            peek(1'b0, v);
            check("R10", "mode kept after software reset", v[4:0], code);
        end

        // Request during a running pulse is ignored (R9)
        write_mode(3);
        @(negedge clk); sw_req = 1'b1;
        @(negedge clk); sw_req = 1'b0;
        n = 0;
        while (pin_drive && n < 1000) begin
            n++;
            sw_req = (n == 5);
            @(negedge clk);
        end
        sw_req = 1'b0;
        check("R9", "pulse not extended", n, 16);
        wait_release();

        // Interrupt mode: synchronizer latency and flag (R3, R4, R5)
        write_mode(32'h12);
        @(negedge clk); ext_lvl = 1'b0;
        step(1);
        peek(1'b1, v);
        check("R3", "level after one edge", v[1], 1);
        check("R4", "flag after one edge", v[0], 0);
        step(1);
        peek(1'b1, v);
        check("R3", "level after two edges", v[1], 0);
        check("R4", "flag after two edges", v[0], 0);
        step(1);
        peek(1'b1, v);
        check("R4", "flag after three edges", v[0], 1);
        check("R5", "irq raised", irq, 1);
        step(5);
        check("R5", "no processor reset", proc_rst_n, 1);
        check("R5", "line not driven", pin_drive, 0);
        read_status(v);
        check("R4", "read returns flag", v[0], 1);
        peek(1'b1, v);
        check("R4", "flag cleared by read", v[0], 0);
        check("R5", "irq dropped", irq, 0);
        step(4);
        peek(1'b1, v);
        check("R4", "no re-set while line held low", v[0], 0);
        ext_lvl = 1'b1;
        step(3);

        // Reset mode: user reset (R6, R8, R10)
        write_mode(32'h02);
        @(negedge clk); ext_lvl = 1'b0;
        step(2);
        check("R6", "no reset before third edge", proc_rst_n, 1);
        step(1);
        check("R6", "reset on third edge", proc_rst_n, 0);
        peek(1'b1, v);
        check("R4", "flag set in reset mode", v[0], 1);
        check("R5", "no irq in reset mode", irq, 0);
        step(10);
        ext_lvl = 1'b1;
        step(2);
        check("R6", "held until third edge after rise", proc_rst_n, 0);
        peek(1'b1, v);
        check("R8", "type unchanged before release", v[10:8], 2);
        step(1);
        check("R6", "released", proc_rst_n, 1);
        peek(1'b1, v);
        check("R6", "type user", v[10:8], 4);
        peek(1'b0, v);
        check("R10", "mode kept after user reset", v[4:0], 2);

        // Second general reset clears mode (R7, R11)
        write_mode(32'h15);
        peek(1'b0, v);
        check("R11", "mode readback", v[4:0], 5'h15);
        @(negedge clk); rst_n = 1'b0;
        step(2);
        peek(1'b0, v);
        check("R7", "mode cleared by general reset", v[4:0], 0);
        rst_n = 1'b1;
        step(2);
        check("R7", "default two-cycle drive", pin_drive, 0);
        wait_release();
        peek(1'b1, v);
        check("R7", "type general again", v[10:8], 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule